// File: doc/BRIEF.md
# Geometry Vertex Emit Buffer

This block sits at the output of a geometry-shader stage and turns two shader commands into vertices and primitives for the next pipeline stage. A set-emit command records which of four vertex slots the next vertex goes into, and whether that vertex closes a primitive. A following emit command copies the stage's whole set of output vector registers into that slot. When the recorded primitive flag is set, the emit also starts a primitive. The block then sends slots 0 up to the emitted slot downstream, in ascending order, on a valid/ready stream.

The slot storage is never cleared between primitives. A shader can therefore rewrite only the slot that changed and still send the full primitive, which reuses vertices from earlier primitives. While a primitive is being sent, the command port reports not-ready, so further commands stall until the downstream side has taken the last vertex. An emit that arrives without a set-emit since reset, or since the previous emit, is dropped and raises a sticky error flag.

The control is a three-state machine. IDLE means nothing is latched. ARMED means a set-emit is held and waiting for its emit. STREAM means a primitive is being sent. The transitions are:

- IDLE to ARMED on an accepted set-emit.
- IDLE to IDLE on an accepted emit, which raises the error.
- ARMED to ARMED on another set-emit, which replaces the latched values.
- ARMED to IDLE on an emit whose primitive flag is clear.
- ARMED to STREAM on an emit whose primitive flag is set.
- STREAM to IDLE when the last vertex is accepted downstream.

Top module: `gs_vertex_emit`

## Requirements
- R1: After reset, cmd_ready is 1, vtx_valid is 0 and emit_err is 0. Every slot holds all zeros.
- R2: A command is accepted in a cycle where cmd_valid and cmd_ready are both 1. Opcode 0x2B in cmd_word[31:26] is a set-emit. It latches the vertex slot from cmd_word[25:24] and sets the primitive flag when cmd_word[23:22] is nonzero.
- R3: An accepted emit (opcode 0x2A in cmd_word[31:26], all other bits unused) that follows a set-emit writes out_regs into the latched slot. When the primitive flag is clear, nothing appears on the vertex stream and cmd_ready stays 1.
- R4: An emit with the primitive flag set makes vtx_valid rise in the next cycle. The block then sends slots 0 through the latched slot in ascending order, with vtx_slot naming each slot and vtx_last high only on the final one.
- R5: Slots are never cleared by sending a primitive. A slot that has not been rewritten is sent with its earlier contents in later primitives.
- R6: An emit with no set-emit since reset or since the previous emit writes nothing and sends nothing. It sets emit_err, which stays 1 until reset.
- R7: While vtx_valid is 1, cmd_ready is 0. While vtx_valid is 1 and vtx_ready is 0, vtx_data and vtx_slot hold their values.
- R8: Accepted commands with any other opcode have no effect on the latched slot, the primitive flag or the stored vertices.
- R9: A second set-emit before the emit replaces both the latched slot and the primitive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_word | input | 32 | Shader command word |
| out_regs | input | NUM_VEC*NUM_COMP*COMP_W (1024) | Current output vector registers, vector 0 in the low bits |
| vtx_valid | output | 1 | Vertex on the stream is valid |
| vtx_ready | input | 1 | Downstream takes the vertex |
| vtx_slot | output | 2 | Slot number of the vertex being sent |
| vtx_data | output | NUM_VEC*NUM_COMP*COMP_W (1024) | Vertex contents of that slot |
| vtx_last | output | 1 | Final vertex of the primitive |
| emit_err | output | 1 | Sticky flag for an emit without a set-emit |

## Verification
The bench targets the following corner cases, each chosen to expose a specific faulty design:

- **Unwritten slot sent right after reset.** A design that did not reset the slots would send garbage.
- **Slot rewritten only in part across primitives.** A design that cleared slots after a primitive would send zeros in place of the reused vertices.
- **Emit without a set-emit, both straight after reset and directly after another emit.** A design that forgot to disarm would write a slot or start a primitive on the second emit.
- **Backpressure from a random vtx_ready while further commands are pending.** A design that let a command through during a primitive, or moved the data during a stall, would reorder or corrupt the scoreboard stream.
- **An overriding set-emit and a foreign opcode carrying set-emit-like field bits.** Either would leave the wrong slot latched in a faulty design.

// File: rtl/gs_emit_pkg.sv
package gs_emit_pkg;
    // Command word field positions (the decoder depends on them)
    localparam int OPC_LSB  = 26;
    localparam int OPC_W    = 6;
    localparam int VID_LSB  = 24;
    localparam int VID_W    = 2;
    localparam int PRIM_LSB = 22;
    localparam int PRIM_W   = 2;
    localparam int CMD_W    = 32;
    localparam int SLOTS    = 1 << VID_W;

    localparam logic [OPC_W-1:0] OPC_SET_EMIT = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_EMIT     = 6'h2A;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_STREAM
    } emit_state_t;
endpackage

// File: rtl/gs_emit_decode.sv
module gs_emit_decode
    import gs_emit_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output logic             is_set,
    output logic             is_emit,
    output logic [VID_W-1:0] vid,
    output logic             prim
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc     = word[OPC_LSB +: OPC_W];
        is_set  = (opc == OPC_SET_EMIT);
        is_emit = (opc == OPC_EMIT);
        vid     = word[VID_LSB +: VID_W];
        prim    = |word[PRIM_LSB +: PRIM_W];
    end
endmodule

// File: rtl/gs_vtx_slots.sv
module gs_vtx_slots
    import gs_emit_pkg::*;
#(
    parameter int VEC_W = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VID_W-1:0] wr_slot,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [VID_W-1:0] rd_slot,
    output logic [VEC_W-1:0] rd_data
);
    logic [SLOTS-1:0][VEC_W-1:0] slot_all;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [VEC_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_slot == VID_W'(g))) begin
                slot_q <= wr_data;
            end
        end

        assign slot_all[g] = slot_q;
    end

    assign rd_data = slot_all[rd_slot];
endmodule

// File: rtl/gs_vertex_emit.sv
module gs_vertex_emit
    import gs_emit_pkg::*;
#(
    parameter int NUM_VEC  = 8,
    parameter int NUM_COMP = 4,
    parameter int COMP_W   = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cmd_valid,
    output logic                                cmd_ready,
    input  logic [CMD_W-1:0]                    cmd_word,
    input  logic [NUM_VEC*NUM_COMP*COMP_W-1:0]  out_regs,
    output logic                                vtx_valid,
    input  logic                                vtx_ready,
    output logic [VID_W-1:0]                    vtx_slot,
    output logic [NUM_VEC*NUM_COMP*COMP_W-1:0]  vtx_data,
    output logic                                vtx_last,
    output logic                                emit_err
);
    localparam int VEC_W = NUM_VEC * NUM_COMP * COMP_W;

    emit_state_t      state_q, state_d;
    logic             dec_set, dec_emit, dec_prim;
    logic [VID_W-1:0] dec_vid;
    logic [VID_W-1:0] vid_q, last_q, rd_ptr_q;
    logic             prim_q, err_q;
    logic             cmd_fire, wr_en, orphan_emit, beat;

    gs_emit_decode u_dec (
        .word    (cmd_word),
        .is_set  (dec_set),
        .is_emit (dec_emit),
        .vid     (dec_vid),
        .prim    (dec_prim)
    );

    gs_vtx_slots #(.VEC_W(VEC_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (vid_q),
        .wr_data (out_regs),
        .rd_slot (rd_ptr_q),
        .rd_data (vtx_data)
    );

    assign cmd_fire    = cmd_valid && cmd_ready;
    assign wr_en       = cmd_fire && dec_emit && (state_q == ST_ARMED);
    assign orphan_emit = cmd_fire && dec_emit && (state_q == ST_IDLE);
    assign beat        = vtx_valid && vtx_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_fire && dec_set) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cmd_fire && dec_emit) state_d = prim_q ? ST_STREAM : ST_IDLE;
            end
            ST_STREAM: begin
                if (beat && vtx_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = (state_q != ST_STREAM);
        vtx_valid = (state_q == ST_STREAM);
        vtx_slot  = rd_ptr_q;
        vtx_last  = vtx_valid && (rd_ptr_q == last_q);
        emit_err  = err_q;
    end

    // Latched command fields, stream pointer, error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_q    <= '0;
            prim_q   <= 1'b0;
            last_q   <= '0;
            rd_ptr_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (cmd_fire && dec_set) begin
                vid_q  <= dec_vid;
                prim_q <= dec_prim;
            end
            if (wr_en) begin
                last_q   <= vid_q;
                rd_ptr_q <= '0;
            end else if (beat && !vtx_last) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            if (orphan_emit) err_q <= 1'b1;
        end
    end

    // Assertions
    assert_cmd_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vtx_valid |-> !cmd_ready);

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vtx_valid && !vtx_ready) |=> (vtx_valid && $stable(vtx_data) && $stable(vtx_slot)));

    assert_slot_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !vtx_last) |=> (vtx_valid && vtx_slot == $past(vtx_slot) + 1'b1));

    assert_start_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vtx_valid) |-> (vtx_slot == '0));

    assert_quiet_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !prim_q) |=> (!vtx_valid && cmd_ready));

    assert_orphan_emit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        orphan_emit |=> (emit_err && !vtx_valid));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        emit_err |=> emit_err);
endmodule

// File: tb/gs_vertex_emit_test.sv
module gs_vertex_emit_test;
    localparam int NUM_VEC  = 8;
    localparam int NUM_COMP = 4;
    localparam int COMP_W   = 32;
    localparam int VEC_W    = NUM_VEC * NUM_COMP * COMP_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [31:0]      cmd_word = '0;
    logic [VEC_W-1:0] out_regs = '0;
    logic             vtx_valid;
    logic             vtx_ready = 1'b1;
    logic [1:0]       vtx_slot;
    logic [VEC_W-1:0] vtx_data;
    logic             vtx_last;
    logic             emit_err;

    int checks = 0;
    int errors = 0;

    // Scoreboard and reference model
    logic [VEC_W-1:0] exp_data_q[$];
    int               exp_slot_q[$];
    bit               exp_last_q[$];
    logic [VEC_W-1:0] mdl [4];
    bit               m_armed, m_prim, m_err;
    int               m_vid;
    bit               rand_ready = 1'b0;
    logic [15:0]      lfsr = 16'hACE1;

    always #4 clk = ~clk;

    gs_vertex_emit #(.NUM_VEC(NUM_VEC), .NUM_COMP(NUM_COMP), .COMP_W(COMP_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .out_regs(out_regs), .vtx_valid(vtx_valid),
        .vtx_ready(vtx_ready), .vtx_slot(vtx_slot), .vtx_data(vtx_data),
        .vtx_last(vtx_last), .emit_err(emit_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [VEC_W-1:0] mkv(input int seed);
        logic [VEC_W-1:0] v;
        for (int i = 0; i < NUM_VEC * NUM_COMP; i++)
            v[i*COMP_W +: COMP_W] = (seed * 32'h0100_0193) ^ (i * 32'h9E37_79B9) ^ 32'h5A5A_0000;
        return v;
    endfunction

    function automatic logic [31:0] set_word(input int vid, input int pf);
        return {6'h2B, 2'(vid), 2'(pf), 22'h0};
    endfunction

    localparam logic [31:0] EMIT_W = {6'h2A, 26'h0};

    // Ready driver
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        vtx_ready = rand_ready ? lfsr[0] : 1'b1;
    end

    // Monitor: pops expected vertices as the design sends them
    logic [VEC_W-1:0] prev_data;
    logic [1:0]       prev_slot;
    bit               prev_stall = 1'b0;
    always begin
        @(negedge clk);
        #1;
        if (rst_n && prev_stall) begin
            check(vtx_valid && vtx_data == prev_data && vtx_slot == prev_slot,
                  "R7 hold during stall", {62'h0, vtx_slot}, {62'h0, prev_slot});
        end
        if (rst_n && vtx_valid) begin
            check(!cmd_ready, "R7 cmd_ready low while sending", 64'(cmd_ready), 64'h0);
        end
        if (rst_n && vtx_valid && vtx_ready) begin
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R3 unexpected vertex on stream", {62'h0, vtx_slot}, 64'hFFFF);
            end else begin
                logic [VEC_W-1:0] ed;
                int es;
                bit el;
                ed = exp_data_q.pop_front();
                es = exp_slot_q.pop_front();
                el = exp_last_q.pop_front();
                check(vtx_slot == 2'(es), "R4 slot order", {62'h0, vtx_slot}, 64'(es));
                check(vtx_data == ed, "R5 slot contents", vtx_data[63:0], ed[63:0]);
                check(vtx_last == el, "R4 last flag", 64'(vtx_last), 64'(el));
            end
        end
        prev_stall = rst_n && vtx_valid && !vtx_ready;
        prev_data  = vtx_data;
        prev_slot  = vtx_slot;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 4; s++) mdl[s] = '0;
        m_armed = 0; m_prim = 0; m_err = 0; m_vid = 0;
        exp_data_q.delete(); exp_slot_q.delete(); exp_last_q.delete();
        rst_n = 1'b1;
        #1;
        check(cmd_ready == 1'b1, "R1 cmd_ready after reset", 64'(cmd_ready), 64'h1);
        check(vtx_valid == 1'b0, "R1 vtx_valid after reset", 64'(vtx_valid), 64'h0);
        check(emit_err == 1'b0, "R1 emit_err after reset", 64'(emit_err), 64'h0);
    endtask

    // Driver: issues a command, updates the model, pushes expected vertices
    task automatic send(input logic [31:0] w, input logic [VEC_W-1:0] regs);
        bit quiet;
        quiet = 0;
        @(negedge clk);
        cmd_word  = w;
        out_regs  = regs;
        cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        if (w[31:26] == 6'h2B) begin
            m_armed = 1;
            m_vid   = int'(w[25:24]);
            m_prim  = |w[23:22];
        end else if (w[31:26] == 6'h2A) begin
            if (!m_armed) begin
                m_err = 1;
                quiet = 1;
            end else begin
                mdl[m_vid] = regs;
                m_armed = 0;
                if (m_prim) begin
                    for (int s = 0; s <= m_vid; s++) begin
                        exp_data_q.push_back(mdl[s]);
                        exp_slot_q.push_back(s);
                        exp_last_q.push_back(s == m_vid);
                    end
                end else begin
                    quiet = 1;
                end
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        if (w[31:26] == 6'h2A) begin
            check(emit_err == m_err, "R6 error flag", 64'(emit_err), 64'(m_err));
            if (quiet)
                check(!vtx_valid && cmd_ready, "R3 no stream after emit",
                      {62'h0, vtx_valid, cmd_ready}, 64'h1);
            else
                check(vtx_valid && vtx_slot == 2'd0, "R4 stream starts at slot 0",
                      {62'h0, vtx_valid, vtx_slot[0]}, 64'h2);
        end
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((exp_data_q.size() != 0 || vtx_valid) && n < 2000) begin
            @(negedge clk);
            #2;
            n++;
        end
        check(exp_data_q.size() == 0, "R4 all expected vertices sent",
              64'(exp_data_q.size()), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R6: emit straight after reset
        send(EMIT_W, mkv(99));
        // R1: reset clears error and slots
        do_reset();
        // R2/R4/R1: slot 0 never written, sent as zeros
        send(set_word(1, 1), '0);
        send(EMIT_W, mkv(1));
        drain();
        // R3: quiet emit into slot 0
        send(set_word(0, 0), '0);
        send(EMIT_W, mkv(2));
        // R5: reuse of slots 0 and 1, prim field 3
        send(set_word(2, 3), '0);
        send(EMIT_W, mkv(3));
        drain();
        // R7: random backpressure with commands queued behind the stream
        rand_ready = 1'b1;
        send(set_word(3, 2), '0);
        send(EMIT_W, mkv(4));
        send(set_word(1, 0), '0);
        send(EMIT_W, mkv(5));
        send(set_word(2, 1), '0);
        send(EMIT_W, mkv(6));
        drain();
        // R9: second set-emit overrides slot and flag
        send(set_word(3, 0), '0);
        send(set_word(1, 1), '0);
        send(EMIT_W, mkv(7));
        drain();
        // R8: foreign opcodes with set-emit-like field bits are ignored
        send(set_word(0, 1), '0);
        send({6'h13, 2'd3, 2'd0, 22'h3FF}, mkv(50));
        send({6'h2C, 2'd2, 2'd0, 22'h0}, mkv(51));
        send(EMIT_W, mkv(8));
        drain();
        // R6: emit right after an emit, then confirm slots unchanged
        send(EMIT_W, mkv(60));
        send(set_word(3, 1), '0);
        send(EMIT_W, mkv(9));
        drain();
        rand_ready = 1'b0;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule